// File: doc/BRIEF.md
# Partition Gather Apply Unit

This unit applies a stream of vertex updates to one graph partition. The labels of the partition's vertices are held in a local RAM while the gather pass runs. Each update carries a global destination vertex index and a value. The unit maps the index to a local slot by subtracting the interval base. It then reads the current label, merges the value into it, and writes the merged label back. Two merge rules are available: keep the smaller value, or add the value to the label. Partitions do not interact, so the unit needs no coordination with any other instance.

The merge is pipelined over three stages, and one update is accepted on every clock. When an update targets a vertex that an earlier update has not yet written back, the newest pending label is forwarded in place of the stale RAM word. A per-vertex activity bit is set whenever a merge changes a label, and a single summary output reports whether any vertex in the partition is active. A start-of-pass pulse clears the activity bits.

A load port fills the RAM before a pass. A readout port returns a vertex's label and activity bit one cycle after the request.

Update back-pressure follows these rules. `upd_ready` is low exactly in the cycles in which `ld_en` is high, and high at every other time. An update is taken on a clock edge where both `upd_valid` and `upd_ready` are high. While `upd_ready` is low, the source must hold its update stable. `op_sel` and `interval_base` must stay constant while updates are in flight. A load or readout of a vertex is only meaningful after that vertex's updates have drained, three edges after acceptance.

Top module: `gather_apply_unit`

## Requirements
- R1: After reset, `any_active` and `rd_valid` are 0. `upd_ready` is 1 while `ld_en` is 0.
- R2: `upd_ready` equals the inverse of `ld_en` in every cycle. An update offered while `ld_en` is high is not taken and changes no label.
- R3: When `ld_en` is high, `ld_data` is written to local slot `ld_addr`. The write takes effect at that clock edge and leaves activity bits unchanged.
- R4: An update's local slot is `upd_dest - interval_base`, taken modulo 2^VTX_W. If that difference is DEPTH or more, the update is accepted and discarded with no effect on labels or activity.
- R5: With `op_sel` = 0, the new label is the unsigned minimum of the old label and the update value.
- R6: With `op_sel` = 1, the new label is the old label plus the update value, modulo 2^LBL_W.
- R7: Every update sees the merged result of all earlier accepted updates to the same vertex. This holds whether they arrived back to back, one cycle apart, or two cycles apart, and no stall is ever inserted.
- R8: A vertex's activity bit is set when a merge yields a label different from the old label. A merge that leaves the label unchanged sets nothing.
- R9: A `pass_start` pulse clears all activity bits on the next edge. If a changing merge writes back on that same edge, its bit is set anyway.
- R10: `any_active` is the OR of all activity bits and follows them with no extra delay.
- R11: A readout requested with `rd_en` at an edge returns `rd_valid` = 1 together with `rd_label` and `rd_active` for `rd_addr` after that edge. Writes made on that same edge are not seen. `rd_valid` is 0 after any edge without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_start | input | 1 | Pulse that clears all activity bits |
| op_sel | input | 1 | Merge rule: 0 minimum, 1 sum |
| interval_base | input | VTX_W | Global index of local slot 0 |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Update can be taken this cycle |
| upd_dest | input | VTX_W | Global destination vertex index |
| upd_value | input | LBL_W | Update value |
| ld_en | input | 1 | Load a label into the RAM |
| ld_addr | input | ADDR_W | Local slot to load |
| ld_data | input | LBL_W | Label to load |
| rd_en | input | 1 | Readout request |
| rd_addr | input | ADDR_W | Local slot to read out |
| rd_valid | output | 1 | Readout data present |
| rd_label | output | LBL_W | Label read out |
| rd_active | output | 1 | Activity bit read out |
| any_active | output | 1 | Some vertex in the partition is active |

## Verification
The hardest cases to reach from the ports are repeated updates to one vertex spaced zero, one and two cycles apart. Only these spacings exercise the two forwarding paths and the path through the RAM. The stimulus confines destinations to four vertices and draws random gaps of zero to two idle cycles, so all three spacings occur many times under both merge rules. A second hard case is a `pass_start` that lands on the same edge as a changing write-back. The bench times this case so that the pulse is sampled exactly two edges after the update is taken.

// File: rtl/gather_pkg.sv
package gather_pkg;

  typedef enum logic {
    OP_MIN = 1'b0,
    OP_SUM = 1'b1
  } combine_op_e;

endpackage

// File: rtl/gather_label_ram.sv
// Interval label storage: one synchronous read for the merge pipeline,
// one synchronous read for readout, one bulk-load write and one merge write.
// A merge write overrides a load to the same slot on the same edge.
module gather_label_ram #(
  parameter int DEPTH  = 64,
  parameter int LBL_W  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              pipe_rd_en,
  input  logic [ADDR_W-1:0] pipe_rd_addr,
  output logic [LBL_W-1:0]  pipe_rd_data,
  input  logic              ro_en,
  input  logic [ADDR_W-1:0] ro_addr,
  output logic [LBL_W-1:0]  ro_data,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LBL_W-1:0]  load_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [LBL_W-1:0]  wb_data
);

  logic [LBL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pipe_rd_en) pipe_rd_data <= mem[pipe_rd_addr];
    if (ro_en)      ro_data      <= mem[ro_addr];
    if (load_en)    mem[load_addr] <= load_data;
    if (wb_en)      mem[wb_addr]   <= wb_data;
  end

endmodule

// File: rtl/gather_combine.sv
// Merge rule applied to one (old label, update value) pair.
module gather_combine
  import gather_pkg::*;
#(
  parameter int LBL_W = 16
) (
  input  combine_op_e      op,
  input  logic [LBL_W-1:0] old_lbl,
  input  logic [LBL_W-1:0] upd_val,
  output logic [LBL_W-1:0] new_lbl,
  output logic             changed
);

  always_comb begin
    unique case (op)
      OP_MIN:  new_lbl = (upd_val < old_lbl) ? upd_val : old_lbl;
      OP_SUM:  new_lbl = old_lbl + upd_val;
      default: new_lbl = old_lbl;
    endcase
    changed = (new_lbl != old_lbl);
  end

endmodule

// File: rtl/gather_active_track.sv
// Per-vertex activity bits: set on a changing write-back, cleared per pass.
// A set on the same edge as a clear wins.
module gather_active_track #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              mark_en,
  input  logic [ADDR_W-1:0] mark_addr,
  input  logic              ro_en,
  input  logic [ADDR_W-1:0] ro_addr,
  output logic              ro_bit,
  output logic              any_set
);

  logic [DEPTH-1:0] act;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                             act[gi] <= 1'b0;
      else if (mark_en && (mark_addr == ADDR_W'(gi)))         act[gi] <= 1'b1;
      else if (clr_all)                                       act[gi] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ro_bit <= 1'b0;
    else if (ro_en) ro_bit <= act[ro_addr];
  end

  assign any_set = |act;

endmodule

// File: rtl/gather_apply_unit.sv
// Pipelined read-merge-write of update streams onto a vertex interval.
//   accept edge : RAM read issued, stage 1 loaded
//   stage 1     : old label chosen (forward from stage 2 / stage 3 / RAM), merged
//   stage 2     : write-back and activity mark on the next edge
//   stage 3     : copy of the last write, kept for forwarding across the RAM read
module gather_apply_unit
  import gather_pkg::*;
#(
  parameter int VTX_W = 16,
  parameter int LBL_W = 16,
  parameter int DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pass_start,
  input  logic                        op_sel,
  input  logic [VTX_W-1:0]            interval_base,
  input  logic                        upd_valid,
  output logic                        upd_ready,
  input  logic [VTX_W-1:0]            upd_dest,
  input  logic [LBL_W-1:0]            upd_value,
  input  logic                        ld_en,
  input  logic [$clog2(DEPTH)-1:0]    ld_addr,
  input  logic [LBL_W-1:0]            ld_data,
  input  logic                        rd_en,
  input  logic [$clog2(DEPTH)-1:0]    rd_addr,
  output logic                        rd_valid,
  output logic [LBL_W-1:0]            rd_label,
  output logic                        rd_active,
  output logic                        any_active
);

  localparam int ADDR_W = $clog2(DEPTH);

  // ---------------- intake and window mapping ----------------
  logic              accept;
  logic [VTX_W-1:0]  offs;
  logic              in_window;
  logic [ADDR_W-1:0] loc_addr;

  assign upd_ready = ~ld_en;
  assign accept    = upd_valid & upd_ready;
  assign offs      = upd_dest - interval_base;
  assign in_window = (offs < VTX_W'(DEPTH));
  assign loc_addr  = offs[ADDR_W-1:0];

  // ---------------- stage 1 ----------------
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [LBL_W-1:0]  s1_val;
  combine_op_e       s1_op;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= accept & in_window;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_addr <= loc_addr;
      s1_val  <= upd_value;
      s1_op   <= combine_op_e'(op_sel);
    end
  end

  // ---------------- stage 2 / stage 3 ----------------
  logic              s2_v, s2_chg;
  logic [ADDR_W-1:0] s2_addr;
  logic [LBL_W-1:0]  s2_new;
  logic              s3_v;
  logic [ADDR_W-1:0] s3_addr;
  logic [LBL_W-1:0]  s3_new;

  // ---------------- RAM ----------------
  logic [LBL_W-1:0] ram_q;

  gather_label_ram #(
    .DEPTH (DEPTH),
    .LBL_W (LBL_W),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk         (clk),
    .pipe_rd_en  (accept),
    .pipe_rd_addr(loc_addr),
    .pipe_rd_data(ram_q),
    .ro_en       (rd_en),
    .ro_addr     (rd_addr),
    .ro_data     (rd_label),
    .load_en     (ld_en),
    .load_addr   (ld_addr),
    .load_data   (ld_data),
    .wb_en       (s2_v),
    .wb_addr     (s2_addr),
    .wb_data     (s2_new)
  );

  // ---------------- forwarding: newest pending result wins ----------------
  logic [LBL_W-1:0] fwd_old;

  always_comb begin
    if (s2_v && (s2_addr == s1_addr))      fwd_old = s2_new;
    else if (s3_v && (s3_addr == s1_addr)) fwd_old = s3_new;
    else                                   fwd_old = ram_q;
  end

  // ---------------- merge ----------------
  logic [LBL_W-1:0] cmb_new;
  logic             cmb_chg;

  gather_combine #(
    .LBL_W(LBL_W)
  ) u_combine (
    .op     (s1_op),
    .old_lbl(fwd_old),
    .upd_val(s1_val),
    .new_lbl(cmb_new),
    .changed(cmb_chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else begin
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v) begin
      s2_addr <= s1_addr;
      s2_new  <= cmb_new;
      s2_chg  <= cmb_chg;
    end
    if (s2_v) begin
      s3_addr <= s2_addr;
      s3_new  <= s2_new;
    end
  end

  // ---------------- activity ----------------
  gather_active_track #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (pass_start),
    .mark_en  (s2_v & s2_chg),
    .mark_addr(s2_addr),
    .ro_en    (rd_en),
    .ro_addr  (rd_addr),
    .ro_bit   (rd_active),
    .any_set  (any_active)
  );

  // ---------------- readout valid ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

endmodule

// File: rtl/gather_apply_unit_chk.sv
module gather_apply_unit_chk #(
  parameter int ADDR_W = 6,
  parameter int LBL_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pass_start,
  input logic              ld_en,
  input logic              upd_ready,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              any_active,
  input logic              s1_v,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s1_is_min,
  input logic [LBL_W-1:0]  fwd_old,
  input logic [LBL_W-1:0]  cmb_new,
  input logic              s2_v,
  input logic              s2_chg,
  input logic [ADDR_W-1:0] s2_addr,
  input logic [LBL_W-1:0]  s2_new
);

  // R2: without a load the unit never refuses an update
  a_r2_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |-> upd_ready);

  // R11: readout answers exactly one cycle after a request
  a_r11_rd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r11_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9: a clear with no coinciding change empties the partition summary
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && !(s2_v && s2_chg)) |=> !any_active);

  // R8: a changing write-back always shows up in the summary
  a_r8_change_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_chg) |=> any_active);

  // R7: back-to-back same-vertex update sees the pending result
  a_r7_forward_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s2_v && (s1_addr == s2_addr)) |-> (fwd_old == s2_new));

  // R5: the minimum rule never raises a label
  a_r5_min_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_is_min) |-> (cmb_new <= fwd_old));

endmodule

bind gather_apply_unit gather_apply_unit_chk #(
  .ADDR_W(ADDR_W),
  .LBL_W (LBL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pass_start(pass_start),
  .ld_en     (ld_en),
  .upd_ready (upd_ready),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .any_active(any_active),
  .s1_v      (s1_v),
  .s1_addr   (s1_addr),
  .s1_is_min (s1_op == gather_pkg::OP_MIN),
  .fwd_old   (fwd_old),
  .cmb_new   (cmb_new),
  .s2_v      (s2_v),
  .s2_chg    (s2_chg),
  .s2_addr   (s2_addr),
  .s2_new    (s2_new)
);

// File: tb/gather_apply_unit_bench.sv
`timescale 1ns/1ps
module gather_apply_unit_bench;

  localparam int VTX_W  = 16;
  localparam int LBL_W  = 16;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 6;
  localparam int BASE   = 100;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pass_start;
  logic              op_sel;
  logic [VTX_W-1:0]  interval_base;
  logic              upd_valid;
  logic              upd_ready;
  logic [VTX_W-1:0]  upd_dest;
  logic [LBL_W-1:0]  upd_value;
  logic              ld_en;
  logic [ADDR_W-1:0] ld_addr;
  logic [LBL_W-1:0]  ld_data;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid;
  logic [LBL_W-1:0]  rd_label;
  logic              rd_active;
  logic              any_active;

  always #2.5 clk = ~clk;

  gather_apply_unit #(
    .VTX_W(VTX_W), .LBL_W(LBL_W), .DEPTH(DEPTH)
  ) u_gather_apply_unit (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .op_sel(op_sel),
    .interval_base(interval_base), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_dest(upd_dest), .upd_value(upd_value), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_label(rd_label), .rd_active(rd_active), .any_active(any_active)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string phase_req = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int ref_lbl [DEPTH];   // logical label after every accepted update
  int ref_mem [DEPTH];   // label as stored, updated when the write lands
  bit ref_act [DEPTH];
  bit q1_v, q2_v, q1_c, q2_c;
  int q1_a, q2_a, q1_d, q2_d;
  bit pend_rd = 1'b0;
  int exp_lbl;
  bit exp_act;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ref_any;
      ref_any = 1'b0;
      foreach (ref_act[i]) ref_any |= ref_act[i];
      check(upd_ready == !ld_en, "R2", "upd_ready", upd_ready, !ld_en);
      check(any_active == ref_any, "R10", "any_active", any_active, ref_any);
      check(rd_valid == pend_rd, "R11", "rd_valid", rd_valid, pend_rd);
      if (pend_rd) begin
        check(int'(rd_label) == exp_lbl, phase_req, "rd_label", rd_label, exp_lbl);
        check(rd_active == exp_act, phase_req, "rd_active", rd_active, exp_act);
      end
      pend_rd = rd_en;
      if (rd_en) begin
        exp_lbl = ref_mem[rd_addr];
        exp_act = ref_act[rd_addr];
      end
      if (ld_en) begin
        ref_mem[ld_addr] = int'(ld_data);
        ref_lbl[ld_addr] = int'(ld_data);
      end
      if (pass_start) foreach (ref_act[i]) ref_act[i] = 1'b0;
      if (q2_v) begin
        ref_mem[q2_a] = q2_d;
        if (q2_c) ref_act[q2_a] = 1'b1;
      end
      q2_v = q1_v; q2_a = q1_a; q2_d = q1_d; q2_c = q1_c;
      q1_v = 1'b0;
      if (upd_valid && !ld_en) begin
        int off, oldv, newv, val;
        off = (int'(upd_dest) - int'(interval_base)) & 'hFFFF;
        if (off < DEPTH) begin
          oldv = ref_lbl[off];
          val  = int'(upd_value);
          if (op_sel) newv = (oldv + val) & 'hFFFF;
          else        newv = (val < oldv) ? val : oldv;
          ref_lbl[off] = newv;
          q1_v = 1'b1; q1_a = off; q1_d = newv; q1_c = (newv != oldv);
        end
      end
    end
  end

  // ---------------- drivers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic send(input int dest, input int val);
    upd_valid = 1'b1;
    upd_dest  = VTX_W'(dest);
    upd_value = LBL_W'(val);
    tick();
    upd_valid = 1'b0;
  endtask

  task automatic load(input int a, input int d);
    ld_en = 1'b1; ld_addr = ADDR_W'(a); ld_data = LBL_W'(d);
    tick();
    ld_en = 1'b0;
  endtask

  task automatic pulse_start();
    pass_start = 1'b1;
    tick();
    pass_start = 1'b0;
  endtask

  task automatic read_all(input string req);
    idle(4);
    phase_req = req;
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1'b1; rd_addr = ADDR_W'(i);
      tick();
    end
    rd_en = 1'b0;
    idle(2);
  endtask

  task automatic random_stream(input int n);
    for (int k = 0; k < n; k++) begin
      send(BASE + int'($urandom % 4), int'($urandom % 3000));
      idle(int'($urandom % 3));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; pass_start = 1'b0; op_sel = 1'b0;
    interval_base = VTX_W'(BASE);
    upd_valid = 1'b0; upd_dest = '0; upd_value = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0; rd_en = 1'b0; rd_addr = '0;
    q1_v = 1'b0; q2_v = 1'b0; q1_c = 1'b0; q2_c = 1'b0;
    q1_a = 0; q2_a = 0; q1_d = 0; q2_d = 0;
    foreach (ref_act[i]) begin ref_act[i] = 1'b0; ref_lbl[i] = 0; ref_mem[i] = 0; end
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    check(any_active == 1'b0, "R1", "any_active after reset", any_active, 0);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    check(upd_ready == 1'b1, "R1", "upd_ready after reset", upd_ready, 1);
    tick();

    // R3 load, with an update held against back-pressure (R2)
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 10) begin upd_valid = 1'b1; upd_dest = VTX_W'(BASE + 2); upd_value = '0; end
      load(i, 1000 + 7 * i);
    end
    upd_valid = 1'b0;
    read_all("R3");
    pulse_start();

    // R5 minimum, directed spacings
    op_sel = 1'b0;
    send(BASE + 5, 500);
    send(BASE + 5, 600);
    send(BASE + 5, 400);
    idle(1);
    send(BASE + 5, 300);
    idle(2);
    send(BASE + 5, 350);
    send(BASE + 10, 65535);
    read_all("R5");

    // R7 dense same-vertex traffic under minimum
    random_stream(200);
    read_all("R7");

    // R4 window mapping: outside slots ignored, last slot accepted
    send(BASE - 1, 0);
    send(BASE + DEPTH, 0);
    send(BASE + DEPTH - 1, 0);
    read_all("R4");

    // R9 clear, then clear coinciding with a changing write-back
    pulse_start();
    read_all("R9");
    send(BASE + 20, 0);
    tick();
    pulse_start();
    idle(4);
    check(any_active == 1'b1, "R9", "set beats same-edge clear", any_active, 1);
    read_all("R9");
    pulse_start();

    // R6 sum with wrap and dense traffic
    op_sel = 1'b1;
    load(3, 'hFFF0);
    send(BASE + 3, 'h20);
    send(BASE + 3, 5);
    random_stream(200);
    read_all("R6");

    // R8 merges that change nothing leave activity clear
    pulse_start();
    idle(4);
    send(BASE + 1, 0);
    send(BASE + 2, 0);
    op_sel = 1'b0;
    send(BASE + 30, 65535);
    send(BASE + 31, 65535);
    idle(4);
    check(any_active == 1'b0, "R8", "no-change merges", any_active, 0);
    read_all("R8");

    finish_run();
  end

endmodule